// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencing Checker

This block sits beside the command bus of a two-bank synchronous DRAM. It samples the clock enable, chip select, row strobe, column strobe, write enable, bank select and auto-precharge address line on every rising clock edge and turns them into a command. It follows each bank through four states: closed, open, bursting, and bursting with auto-precharge. It also counts the wait that follows a mode register write.

When a command breaks a sequencing rule, the block raises a one-clock violation pulse together with a 3-bit reason code. A rejected command does not change the tracked bank state.

The block also derives the data masks implied by the DQM pin. The write mask follows DQM in the same cycle. The read mask follows DQM two clocks later. A verification environment or a memory controller's self-check logic instantiates this block and watches `violation`, `errCode` and `bankOpen`.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With `cke` high and `csN` low, `{rasN,casN,weN}` decodes as follows: 111 is no-op, 011 is activate, 101 is read, 100 is write, 110 is burst stop, 010 is precharge, 001 is refresh and 000 is mode register write. With `csN` high the command is a no-op. With `cke` low, only the refresh pattern counts (as self-refresh entry); every other pattern is ignored.
- R2: A mode register write is legal only when both banks are closed, whichever register `ba` selects (0 standard, 1 extended). Otherwise it reports code 1.
- R3: With the default wait of 2, any command other than a no-op on the first edge after an accepted mode register write reports code 2 and is rejected. A command on the second edge is accepted normally.
- R4: Refresh and self-refresh entry are legal only when both banks are closed. Otherwise they report code 3.
- R5: After a read or write with `addrAp` high, any read or write on the next BURST_LEN-1 edges (default 3) reports code 4. The target bank is closed from edge BURST_LEN onward.
- R6: A read or write to a closed bank reports code 5.
- R7: An activate to a bank that is not closed reports code 6. An activate to a closed bank opens it.
- R8: A precharge with `addrAp` high closes both banks whatever `ba` holds. With `addrAp` low it closes only the bank that `ba` selects (0 bank A, 1 bank B).
- R9: Burst stop, and a read or write that cuts short a plain burst in the other bank, are accepted without a violation and leave the banks open.
- R10: `violation` and `errCode` are registered. They are valid for exactly the one cycle after the edge that sampled the command, and a rejected command leaves `bankOpen` unchanged.
- R11: `wrMask` equals `dqm` in the same cycle (write latency 0).
- R12: DQM sampled high at edge k drives `rdMask` high from edge k+1 to edge k+2 (read latency 2).
- R13: During and right after reset, `violation`, `errCode`, `bankOpen` and `rdMask` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addrAp | input | 1 | Auto-precharge / all-banks address line |
| dqm | input | 1 | Data mask pin |
| violation | output | 1 | One-cycle pulse on a rule breach |
| errCode | output | 3 | Reason code for the current pulse, 0 when none |
| bankOpen | output | 2**BA_W | One bit per bank, high when the bank is not closed |
| wrMask | output | 1 | Write data mask, latency 0 |
| rdMask | output | 1 | Read output high-impedance mask, latency 2 |

## Verification
The results fall due at different times. The verdict and the bank-open flags for a command sampled at edge k appear just after edge k. `wrMask` follows `dqm` within the same cycle. `rdMask` rises only after edge k+1. The bench changes inputs on the falling edge and samples one falling edge later, so every verdict is read in exactly the cycle it belongs to. The read mask is sampled over three successive falling edges to show that it is low, then high, then low again.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_BST, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_OPEN, BK_BURST, BK_BURST_AP
  } bank_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_MRS_BUSY  = 3'd1,
    ERR_MRD_WAIT  = 3'd2,
    ERR_REF_BUSY  = 3'd3,
    ERR_AP_LOCK   = 3'd4,
    ERR_BANK_IDLE = 3'd5,
    ERR_ACT_OPEN  = 3'd6
  } err_e;

  typedef struct packed {
    logic loadMrd;
    logic loadBurst;
    logic flagErr;
    err_e errCode;
  } strobe_t;

endpackage

// File: rtl/sdram_chk_datapath.sv
module sdram_chk_datapath
  import sdram_chk_pkg::*;
#(
  parameter int BURST_LEN  = 4,
  parameter int MRD_CYC    = 2,
  parameter int RD_DQM_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       dqm,
  input  strobe_t    strb,
  output cmd_e       cmd,
  output logic       mrdBusy,
  output logic       burstDone,
  output logic       violation,
  output logic [2:0] errCode,
  output logic       wrMask,
  output logic       rdMask
);

  localparam int BCNT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
  localparam int MRD_W  = $clog2(MRD_CYC + 1);
  localparam logic [BCNT_W-1:0] BURST_RELOAD = BCNT_W'(BURST_LEN - 2);
  localparam logic [MRD_W-1:0]  MRD_RELOAD   = MRD_W'(MRD_CYC - 1);

  logic [2:0]        pinCode;
  logic [BCNT_W-1:0] burstCnt;
  logic [MRD_W-1:0]  mrdCnt;
  logic              violReg;
  err_e              errReg;

  assign pinCode = {rasN, casN, weN};

  // pin decode
  always_comb begin
    cmd = CMD_NOP;
    if (!cke) begin
      if (!csN && pinCode == 3'b001) cmd = CMD_REF;
    end else if (!csN) begin
      unique case (pinCode)
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  // burst length counter
  always_ff @(posedge clk) begin
    if (!rstN)               burstCnt <= '0;
    else if (strb.loadBurst) burstCnt <= BURST_RELOAD;
    else if (burstCnt != '0) burstCnt <= burstCnt - 1'b1;
  end
  assign burstDone = (burstCnt == '0);

  // wait after mode register write
  always_ff @(posedge clk) begin
    if (!rstN)             mrdCnt <= '0;
    else if (strb.loadMrd) mrdCnt <= MRD_RELOAD;
    else if (mrdCnt != '0) mrdCnt <= mrdCnt - 1'b1;
  end
  assign mrdBusy = (mrdCnt != '0);

  // violation report register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      violReg <= 1'b0;
      errReg  <= ERR_NONE;
    end else begin
      violReg <= strb.flagErr;
      errReg  <= strb.flagErr ? strb.errCode : ERR_NONE;
    end
  end
  assign violation = violReg;
  assign errCode   = errReg;

  // DQM masks
  assign wrMask = dqm;

  logic [RD_DQM_LAT-1:0] dqmPipe;
  for (genvar s = 0; s < RD_DQM_LAT; s++) begin : g_dqm
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) dqmPipe[s] <= 1'b0;
        else       dqmPipe[s] <= dqm;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rstN) dqmPipe[s] <= 1'b0;
        else       dqmPipe[s] <= dqmPipe[s-1];
      end
    end
  end
  assign rdMask = dqmPipe[RD_DQM_LAT-1];

  AST_MRD_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMrd |=> mrdBusy); // R3
  AST_WAIT_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    mrdBusy |-> !(strb.loadMrd || strb.loadBurst)); // R3

endmodule

// File: rtl/sdram_chk_control.sv
module sdram_chk_control
  import sdram_chk_pkg::*;
#(
  parameter int BA_W = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cmd_e                    cmd,
  input  logic [BA_W-1:0]         ba,
  input  logic                    addrAp,
  input  logic                    mrdBusy,
  input  logic                    burstDone,
  output strobe_t                 strb,
  output logic [(1<<BA_W)-1:0]    bankOpen
);

  localparam int NUM_BANKS = 1 << BA_W;

  bank_e bankSt  [NUM_BANKS];
  bank_e bankNxt [NUM_BANKS];
  logic  allIdle;
  logic  anyAp;

  always_comb begin
    allIdle = 1'b1;
    anyAp   = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bankSt[i] != BK_IDLE)     allIdle = 1'b0;
      if (bankSt[i] == BK_BURST_AP) anyAp   = 1'b1;
    end
  end

  always_comb begin
    bankNxt      = bankSt;
    strb         = '0;
    strb.errCode = ERR_NONE;

    // natural burst end
    if (burstDone) begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (bankSt[i] == BK_BURST)    bankNxt[i] = BK_OPEN;
        if (bankSt[i] == BK_BURST_AP) bankNxt[i] = BK_IDLE;
      end
    end

    if (cmd != CMD_NOP && mrdBusy) begin
      strb.flagErr = 1'b1;
      strb.errCode = ERR_MRD_WAIT;
    end else begin
      unique case (cmd)
        CMD_MRS: begin
          if (!allIdle) begin
            strb.flagErr = 1'b1;
            strb.errCode = ERR_MRS_BUSY;
          end else begin
            strb.loadMrd = 1'b1;
          end
        end
        CMD_REF: begin
          if (!allIdle) begin
            strb.flagErr = 1'b1;
            strb.errCode = ERR_REF_BUSY;
          end
        end
        CMD_ACT: begin
          if (bankSt[ba] != BK_IDLE) begin
            strb.flagErr = 1'b1;
            strb.errCode = ERR_ACT_OPEN;
          end else begin
            bankNxt[ba] = BK_OPEN;
          end
        end
        CMD_RD, CMD_WR: begin
          if (anyAp) begin
            strb.flagErr = 1'b1;
            strb.errCode = ERR_AP_LOCK;
          end else if (bankSt[ba] == BK_IDLE) begin
            strb.flagErr = 1'b1;
            strb.errCode = ERR_BANK_IDLE;
          end else begin
            strb.loadBurst = 1'b1;
            for (int i = 0; i < NUM_BANKS; i++) begin
              if (BA_W'(i) == ba)
                bankNxt[i] = addrAp ? BK_BURST_AP : BK_BURST;
              else if (bankNxt[i] == BK_BURST)
                bankNxt[i] = BK_OPEN;
            end
          end
        end
        CMD_PRE: begin
          if (addrAp) begin
            for (int i = 0; i < NUM_BANKS; i++) bankNxt[i] = BK_IDLE;
          end else begin
            bankNxt[ba] = BK_IDLE;
          end
        end
        CMD_BST: begin
          for (int i = 0; i < NUM_BANKS; i++) begin
            if (bankSt[i] == BK_BURST)    bankNxt[i] = BK_OPEN;
            if (bankSt[i] == BK_BURST_AP) bankNxt[i] = BK_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (!rstN) bankSt[i] <= BK_IDLE;
      else       bankSt[i] <= bankNxt[i];
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_open
    assign bankOpen[g] = (bankSt[g] != BK_IDLE);
  end

  AST_MRS_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMrd |=> allIdle); // R2
  AST_AP_BLOCKS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    anyAp |-> !strb.loadBurst); // R5

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int BA_W       = 1,
  parameter int BURST_LEN  = 4,
  parameter int MRD_CYC    = 2,
  parameter int RD_DQM_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      ba,
  input  logic                 addrAp,
  input  logic                 dqm,
  output logic                 violation,
  output logic [2:0]           errCode,
  output logic [(1<<BA_W)-1:0] bankOpen,
  output logic                 wrMask,
  output logic                 rdMask
);

  cmd_e    cmd;
  strobe_t strb;
  logic    mrdBusy;
  logic    burstDone;

  sdram_chk_datapath #(
    .BURST_LEN (BURST_LEN),
    .MRD_CYC   (MRD_CYC),
    .RD_DQM_LAT(RD_DQM_LAT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .dqm      (dqm),
    .strb     (strb),
    .cmd      (cmd),
    .mrdBusy  (mrdBusy),
    .burstDone(burstDone),
    .violation(violation),
    .errCode  (errCode),
    .wrMask   (wrMask),
    .rdMask   (rdMask)
  );

  sdram_chk_control #(
    .BA_W(BA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .ba       (ba),
    .addrAp   (addrAp),
    .mrdBusy  (mrdBusy),
    .burstDone(burstDone),
    .strb     (strb),
    .bankOpen (bankOpen)
  );

  // cycles since reset, only to keep the latency check inside that window
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_RD_MASK_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (rdMask == $past(dqm, 2))); // R12
  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (errCode != 3'd0 && errCode != 3'd7)); // R10

endmodule

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [0:0] ba = 1'b0;
  logic       addrAp = 1'b0, dqm = 1'b0;
  logic       violation, wrMask, rdMask;
  logic [2:0] errCode;
  logic [1:0] bankOpen;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_checker u_sdram_cmd_checker (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addrAp(addrAp), .dqm(dqm), .violation(violation),
    .errCode(errCode), .bankOpen(bankOpen), .wrMask(wrMask), .rdMask(rdMask)
  );

  // fields: req[15:12] cke[11] csN[10] rcw[9:7] ba[6] ap[5] code[4:2] open[1:0]
  localparam int NVEC = 30;
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd1,  1'b1,1'b0,3'b111,1'b0,1'b0,3'd0,2'b00}, // 0  R1 no-op
    {4'd2,  1'b1,1'b0,3'b000,1'b0,1'b0,3'd0,2'b00}, // 1  R2 MRS when closed
    {4'd3,  1'b1,1'b0,3'b011,1'b0,1'b0,3'd2,2'b00}, // 2  R3 act inside wait
    {4'd3,  1'b1,1'b0,3'b011,1'b0,1'b0,3'd0,2'b01}, // 3  R3 act after wait
    {4'd2,  1'b1,1'b0,3'b000,1'b1,1'b0,3'd1,2'b01}, // 4  R2 ext MRS, bank open
    {4'd4,  1'b1,1'b0,3'b001,1'b0,1'b0,3'd3,2'b01}, // 5  R4 refresh, bank open
    {4'd7,  1'b1,1'b0,3'b011,1'b0,1'b0,3'd6,2'b01}, // 6  R7 act open bank
    {4'd6,  1'b1,1'b0,3'b101,1'b1,1'b0,3'd5,2'b01}, // 7  R6 read closed bank
    {4'd5,  1'b1,1'b0,3'b101,1'b0,1'b1,3'd0,2'b01}, // 8  R5 read with AP
    {4'd5,  1'b1,1'b0,3'b100,1'b0,1'b0,3'd4,2'b01}, // 9  R5 write in lockout
    {4'd10, 1'b1,1'b0,3'b111,1'b0,1'b0,3'd0,2'b01}, // 10 R10 pulse ends
    {4'd5,  1'b1,1'b0,3'b101,1'b1,1'b0,3'd4,2'b00}, // 11 R5 last locked edge
    {4'd5,  1'b1,1'b0,3'b101,1'b0,1'b0,3'd5,2'b00}, // 12 R5 bank closed by AP
    {4'd7,  1'b1,1'b0,3'b011,1'b1,1'b0,3'd0,2'b10}, // 13 R7 open bank B
    {4'd9,  1'b1,1'b0,3'b101,1'b1,1'b0,3'd0,2'b10}, // 14 R9 plain read B
    {4'd7,  1'b1,1'b0,3'b011,1'b0,1'b0,3'd0,2'b11}, // 15 R7 open bank A
    {4'd9,  1'b1,1'b0,3'b100,1'b0,1'b0,3'd0,2'b11}, // 16 R9 write A cuts B
    {4'd9,  1'b1,1'b0,3'b110,1'b0,1'b0,3'd0,2'b11}, // 17 R9 burst stop
    {4'd8,  1'b1,1'b0,3'b010,1'b1,1'b1,3'd0,2'b00}, // 18 R8 precharge all
    {4'd8,  1'b1,1'b0,3'b101,1'b0,1'b0,3'd5,2'b00}, // 19 R8 A really closed
    {4'd4,  1'b1,1'b0,3'b001,1'b0,1'b0,3'd0,2'b00}, // 20 R4 refresh closed
    {4'd4,  1'b0,1'b0,3'b001,1'b0,1'b0,3'd0,2'b00}, // 21 R4 self refresh
    {4'd1,  1'b0,1'b0,3'b101,1'b0,1'b0,3'd0,2'b00}, // 22 R1 cke low ignored
    {4'd10, 1'b1,1'b0,3'b101,1'b0,1'b0,3'd5,2'b00}, // 23 R10 state untouched
    {4'd1,  1'b1,1'b1,3'b101,1'b0,1'b0,3'd0,2'b00}, // 24 R1 deselect
    {4'd2,  1'b1,1'b0,3'b000,1'b1,1'b0,3'd0,2'b00}, // 25 R2 ext MRS closed
    {4'd3,  1'b1,1'b0,3'b011,1'b1,1'b0,3'd2,2'b00}, // 26 R3 wait again
    {4'd3,  1'b1,1'b0,3'b011,1'b1,1'b0,3'd0,2'b10}, // 27 R3 act B allowed
    {4'd8,  1'b1,1'b0,3'b010,1'b1,1'b0,3'd0,2'b00}, // 28 R8 single precharge B
    {4'd8,  1'b1,1'b0,3'b101,1'b1,1'b0,3'd5,2'b00}  // 29 R8 B closed
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic driveNop();
    cke = 1'b1; csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    ba = 1'b0; addrAp = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    driveNop();
    dqm = 1'b0;
    repeat (3) @(negedge clk);
    // R13 outputs during reset
    check(violation == 1'b0 && errCode == 3'd0, "R13", "err in reset", errCode, 0);
    check(bankOpen == 2'b00 && rdMask == 1'b0, "R13", "open in reset", bankOpen, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(violation == 1'b0 && errCode == 3'd0, "R13", "err after reset", errCode, 0);
    check(bankOpen == 2'b00, "R13", "open after reset", bankOpen, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      string req;
      v = VEC[i];
      cke = v[11]; csN = v[10]; {rasN, casN, weN} = v[9:7];
      ba = v[6]; addrAp = v[5];
      @(negedge clk);
      req = $sformatf("R%0d", v[15:12]);
      check(errCode == v[4:2], req, $sformatf("code vec%0d", i), errCode, v[4:2]);
      check(violation == (v[4:2] != 3'd0), req, $sformatf("viol vec%0d", i),
            violation, (v[4:2] != 3'd0));
      check(bankOpen == v[1:0], req, $sformatf("open vec%0d", i), bankOpen, v[1:0]);
    end
    driveNop();
    @(negedge clk);
    check(violation == 1'b0, "R10", "pulse cleared", violation, 0);

    // R11 write mask follows dqm at once
    dqm = 1'b1;
    #1;
    check(wrMask == 1'b1, "R11", "wrMask high", wrMask, 1);
    // R12 read mask two edges later
    @(negedge clk);                    // edge k sampled dqm=1
    check(rdMask == 1'b0, "R12", "rdMask after k", rdMask, 0);
    dqm = 1'b0;
    #1;
    check(wrMask == 1'b0, "R11", "wrMask low", wrMask, 0);
    @(negedge clk);                    // edge k+1
    check(rdMask == 1'b1, "R12", "rdMask after k+1", rdMask, 1);
    @(negedge clk);                    // edge k+2
    check(rdMask == 1'b0, "R12", "rdMask after k+2", rdMask, 0);

    // R13 reset in the middle clears open banks
    cke = 1'b1; csN = 1'b0; {rasN, casN, weN} = 3'b011; ba = 1'b1;
    @(negedge clk);
    driveNop();
    check(bankOpen == 2'b10, "R7", "bank B opened", bankOpen, 2);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(bankOpen == 2'b00, "R13", "reset closes banks", bankOpen, 0);
    finish();
  end

endmodule